// File: doc/BRIEF.md
# Eight-Bit Timer with Two Compare-Match Waveform Channels

The block is an 8-bit counter that advances once per cycle on which the `tick` input is high. The tick comes from a prescaler outside the block. Two compare channels watch the counter. Each one raises a sticky match flag and drives a waveform pin according to the current counting mode and that channel's output-mode field. A sticky overflow flag marks the end of each counting period.

Software reaches the block through one write port. `wr_sel` chooses the target and `wr_data` carries the value. There are four counting modes:
- free-running up count
- up count that restarts after matching compare value A
- single-slope PWM
- dual-slope (up/down) PWM

In the two PWM modes the compare values are double-buffered, so the duty cycle never changes in the middle of a period. A write to the counter hides the next compare match. The force strobes apply a compare action at once, and they do this only in the two non-PWM modes.

Top module: `tmr8_pwm`

## Requirements
- R1: Write-select codes: 0 counter, 1 compare A, 2 compare B, 3 mode (data bits 1:0; 0 free-running, 1 clear-on-match-A, 2 single-slope PWM, 3 dual-slope PWM), 4 output modes (channel A bits 1:0, channel B bits 3:2), 5 force strobes (bit 0 A, bit 1 B), 6 flag clear (bit 0 match A, bit 1 match B, bit 2 overflow). A counter write takes priority over a tick in the same cycle.
- R2: In free-running and single-slope PWM modes, each tick adds one to the counter, and the counter wraps from 255 to 0. The overflow flag is set on the tick that leaves 255.
- R3: In clear-on-match-A mode, the tick that finds the counter equal to compare A loads 0. With compare A at 0 and toggle output, the pin changes on every tick.
- R4: In the non-PWM modes, a compare match applies the output mode: 1 toggles the pin, 2 drives it low, 3 drives it high. Output mode 0 holds the pin low.
- R5: In single-slope PWM, output mode 2 sets the pin on the tick that leaves 255 and clears it on a compare match. Output mode 3 does the inverse. Modes 0 and 1 hold the pin low.
- R6: In dual-slope PWM, the counter runs 0 up to 255 and back down to 0 (510 ticks per period). With output mode 2, a match while counting up clears the pin and a match while counting down sets it. Mode 3 is the inverse. The overflow flag is set on the tick that turns at 0, and not at 255.
- R7: In dual-slope PWM, a compare value of 0 holds the pin low and a compare value of 255 holds it high with output mode 2. Mode 3 gives the opposite levels.
- R8: In the PWM modes, a compare write goes only to a buffer. The buffer becomes the active compare value on the tick that finds the counter at 255. In the non-PWM modes, a compare write takes effect at once.
- R9: A counter write suppresses the compare match (flag and pin action) on the first tick after it.
- R10: A force strobe applies the channel's compare action in the non-PWM modes. It sets no flag and does not change the counter. In the PWM modes it has no effect.
- R11: The match flags and the overflow flag stay set until a flag-clear write with a one in their bit.
- R12: After reset, the counter, both compare values, the output modes, all flags and both pins are zero, and the mode is free-running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter enable pulse from the external prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target select (see R1) |
| wr_data | input | 8 | Write data |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| match_flag | output | 2 | Sticky compare-match flags, bit 0 A, bit 1 B |
| ovf_flag | output | 1 | Sticky overflow flag |
| count | output | 8 | Current counter value |

## Verification
A table of vectors runs each counting mode from a chosen start value for a chosen number of ticks. It then compares the counter, pin A and match flag A. The tick counts are placed one tick before and one tick after the expected match, so that an off-by-one edge in any mode is caught.

Start values near 255 separate the wrap, turn and reload points of the two PWM shapes. Compare values 0 and 255 in dual-slope mode separate the fixed-level rule from ordinary matches. Directed sequences then check the following:
- a compare rewrite in the middle of a period must not act before the next reload;
- the force strobe must act, or be ignored, depending on the mode;
- the overflow flag must be set at 255 in one mode and at 0 in the other;
- channel B must work on its own.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_CTC    = 2'd1,
        MODE_FAST   = 2'd2,
        MODE_PHASE  = 2'd3
    } tmr_mode_e;

    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_COUNT = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CMPA  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_MODE  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_OMODE = 3'd4;
    localparam logic [SEL_W-1:0] SEL_FORCE = 3'd5;
    localparam logic [SEL_W-1:0] SEL_FLAGS = 3'd6;

    localparam logic [1:0] OM_OFF    = 2'd0;
    localparam logic [1:0] OM_TOGGLE = 2'd1;
    localparam logic [1:0] OM_CLEAR  = 2'd2;
    localparam logic [1:0] OM_SET    = 2'd3;

    function automatic logic mode_is_pwm(tmr_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  tmr_mode_e    mode_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] top_i,
    output logic [W-1:0] cnt_o,
    output logic         up_o,
    output logic         step_o,
    output logic         max_evt_o,
    output logic         bottom_evt_o,
    output logic         block_o
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         up;
        logic         blk;
    } cstate_t;

    cstate_t st_d, st_q;
    logic    step;

    always_comb begin
        st_d = st_q;
        step = tick_i && !load_i;
        if (mode_i != MODE_PHASE) st_d.up = 1'b1;
        if (load_i) begin
            st_d.cnt = load_val_i;
            st_d.blk = 1'b1;
        end else if (tick_i) begin
            st_d.blk = 1'b0;
            case (mode_i)
                MODE_CTC: st_d.cnt = (st_q.cnt == top_i) ? '0 : st_q.cnt + 1'b1;
                MODE_PHASE: begin
                    if (st_q.up) begin
                        if (st_q.cnt == MAXV) begin
                            st_d.cnt = MAXV - 1'b1;
                            st_d.up  = 1'b0;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end else begin
                        if (st_q.cnt == '0) begin
                            st_d.cnt = ONE;
                            st_d.up  = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt - 1'b1;
                        end
                    end
                end
                default: st_d.cnt = st_q.cnt + 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, up: 1'b1, blk: 1'b0};
        else        st_q <= st_d;
    end

    assign cnt_o        = st_q.cnt;
    assign up_o         = st_q.up;
    assign step_o       = step;
    assign block_o      = st_q.blk;
    assign max_evt_o    = step && (st_q.cnt == MAXV);
    assign bottom_evt_o = step && (mode_i == MODE_PHASE) && !st_q.up && (st_q.cnt == '0);

    // R2: single-slope counting wraps from the top value to zero
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (mode_i == MODE_NORMAL || mode_i == MODE_FAST) && st_q.cnt == MAXV)
        |=> (st_q.cnt == '0));

    // R6: dual-slope counting turns upward at zero
    a_r6_turn_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode_i == MODE_PHASE && !st_q.up && st_q.cnt == '0)
        |=> (st_q.up && st_q.cnt == ONE));

    // R1: a counter write lands regardless of tick
    a_r1_count_write: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.cnt == $past(load_val_i)));

endmodule

// File: rtl/tmr8_chan.sv
module tmr8_chan
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  tmr_mode_e    mode_i,
    input  logic [W-1:0] cnt_i,
    input  logic         up_i,
    input  logic         block_i,
    input  logic         max_evt_i,
    input  logic         wr_cmp_i,
    input  logic [W-1:0] wr_val_i,
    input  logic [1:0]   om_i,
    input  logic         force_i,
    output logic         match_o,
    output logic         wave_o,
    output logic [W-1:0] active_o
);
    localparam logic [W-1:0] MAXV = '1;

    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] act;
        logic         oc;
    } chstate_t;

    chstate_t ch_d, ch_q;
    logic     pwm, hit, inv;

    always_comb begin
        ch_d = ch_q;
        pwm  = mode_is_pwm(mode_i);
        hit  = step_i && !block_i && (cnt_i == ch_q.act);
        inv  = (om_i == OM_SET);

        if (wr_cmp_i) begin
            ch_d.shadow = wr_val_i;
            if (!pwm) ch_d.act = wr_val_i;
        end
        if (pwm && max_evt_i) ch_d.act = ch_q.shadow;

        case (mode_i)
            MODE_FAST: begin
                if (om_i[1]) begin
                    if (max_evt_i)  ch_d.oc = !inv;
                    else if (hit)   ch_d.oc = inv;
                end
            end
            MODE_PHASE: begin
                if (om_i[1] && step_i) begin
                    if (ch_q.act == '0)        ch_d.oc = inv;
                    else if (ch_q.act == MAXV) ch_d.oc = !inv;
                    else if (hit)              ch_d.oc = up_i ? inv : !inv;
                end
            end
            default: begin
                if ((hit || force_i) && om_i != OM_OFF) begin
                    case (om_i)
                        OM_TOGGLE: ch_d.oc = !ch_q.oc;
                        OM_CLEAR:  ch_d.oc = 1'b0;
                        default:   ch_d.oc = 1'b1;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign match_o  = hit;
    assign active_o = ch_q.act;
    assign wave_o   = pwm ? (om_i[1] & ch_q.oc) : ((om_i != OM_OFF) & ch_q.oc);

    // R8: in PWM modes the active compare value moves only at the reload point
    a_r8_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_is_pwm(mode_i) && !max_evt_i) |=> $stable(ch_q.act));

    // R10: with no tick in a PWM mode the output level cannot move, force or not
    a_r10_pwm_force_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_is_pwm(mode_i) && !step_i) |=> $stable(ch_q.oc));

    // R7: dual-slope with compare zero and non-inverted output is held low
    a_r7_phase_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_PHASE && step_i && om_i == OM_CLEAR && ch_q.act == '0)
        |=> !ch_q.oc);

endmodule

// File: rtl/tmr8_pwm.sv
module tmr8_pwm
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [2:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic         wave_a,
    output logic         wave_b,
    output logic [1:0]   match_flag,
    output logic         ovf_flag,
    output logic [W-1:0] count
);
    localparam int NCH = 2;

    typedef struct packed {
        tmr_mode_e        mode;
        logic [2*NCH-1:0] om;
        logic [NCH-1:0]   mflag;
        logic             ovf;
    } regs_t;

    regs_t rg_d, rg_q;

    logic [W-1:0]   cnt;
    logic           up, step, max_evt, bottom_evt, blk, ovf_evt;
    logic [NCH-1:0] match, wave;
    logic [W-1:0]   act [NCH];

    tmr8_counter #(.W(W)) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .mode_i       (rg_q.mode),
        .load_i       (wr_en && wr_sel == SEL_COUNT),
        .load_val_i   (wr_data),
        .top_i        (act[0]),
        .cnt_o        (cnt),
        .up_o         (up),
        .step_o       (step),
        .max_evt_o    (max_evt),
        .bottom_evt_o (bottom_evt),
        .block_o      (blk)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [SEL_W-1:0] CSEL = SEL_CMPA + SEL_W'(c);
        tmr8_chan #(.W(W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .step_i    (step),
            .mode_i    (rg_q.mode),
            .cnt_i     (cnt),
            .up_i      (up),
            .block_i   (blk),
            .max_evt_i (max_evt),
            .wr_cmp_i  (wr_en && wr_sel == CSEL),
            .wr_val_i  (wr_data),
            .om_i      (rg_q.om[2*c +: 2]),
            .force_i   (wr_en && wr_sel == SEL_FORCE && wr_data[c]),
            .match_o   (match[c]),
            .wave_o    (wave[c]),
            .active_o  (act[c])
        );
    end

    assign ovf_evt = ((rg_q.mode != MODE_PHASE) && max_evt) || bottom_evt;

    always_comb begin
        rg_d = rg_q;
        if (wr_en && wr_sel == SEL_MODE)  rg_d.mode = tmr_mode_e'(wr_data[1:0]);
        if (wr_en && wr_sel == SEL_OMODE) rg_d.om   = wr_data[2*NCH-1:0];
        if (wr_en && wr_sel == SEL_FLAGS) begin
            rg_d.mflag = rg_d.mflag & ~wr_data[NCH-1:0];
            rg_d.ovf   = rg_d.ovf & ~wr_data[NCH];
        end
        rg_d.mflag = rg_d.mflag | match;
        rg_d.ovf   = rg_d.ovf | ovf_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign wave_a     = wave[0];
    assign wave_b     = wave[1];
    assign match_flag = rg_q.mflag;
    assign ovf_flag   = rg_q.ovf;
    assign count      = cnt;

    // R11: overflow flag stays set without a clearing write
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.ovf && !(wr_en && wr_sel == SEL_FLAGS && wr_data[NCH])) |=> rg_q.ovf);

    // R10: a force strobe with no tick leaves match flag A clear
    a_r10_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_FORCE && !tick && !rg_q.mflag[0]) |=> !rg_q.mflag[0]);

    // R9: the tick following a counter write cannot raise match flag A
    a_r9_blocked_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && tick && !wr_en && !rg_q.mflag[0]) |=> !rg_q.mflag[0]);

endmodule

// File: tb/tmr8_pwm_bench.sv
module tmr8_pwm_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic       wave_a, wave_b, ovf_flag;
    logic [1:0] match_flag;
    logic [7:0] count;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr8_pwm u_tmr8_pwm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .wave_a(wave_a), .wave_b(wave_b),
        .match_flag(match_flag), .ovf_flag(ovf_flag), .count(count)
    );

    typedef struct packed {
        logic [7:0]  tag;
        logic [1:0]  mode;
        logic [7:0]  cmp;
        logic [1:0]  om;
        logic [7:0]  start;
        logic [15:0] n;
        logic [7:0]  ecnt;
        logic        ewave;
        logic        eflag;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{8'd4, 2'd0, 8'd10,  2'd1, 8'd5,   16'd6,   8'd11,  1'b1, 1'b1}, // R4 toggle in free-running
        '{8'd9, 2'd0, 8'd10,  2'd1, 8'd10,  16'd1,   8'd11,  1'b0, 1'b0}, // R9 blocked match
        '{8'd3, 2'd1, 8'd3,   2'd1, 8'd0,   16'd4,   8'd0,   1'b1, 1'b1}, // R3 restart at compare A
        '{8'd3, 2'd1, 8'd3,   2'd1, 8'd0,   16'd8,   8'd0,   1'b0, 1'b1}, // R3 second toggle
        '{8'd3, 2'd1, 8'd3,   2'd1, 8'd0,   16'd5,   8'd1,   1'b1, 1'b1}, // R3
        '{8'd3, 2'd1, 8'd0,   2'd1, 8'd0,   16'd2,   8'd0,   1'b1, 1'b1}, // R3 compare zero
        '{8'd3, 2'd1, 8'd0,   2'd1, 8'd0,   16'd3,   8'd0,   1'b0, 1'b1}, // R3 toggles every tick
        '{8'd5, 2'd2, 8'd100, 2'd2, 8'd250, 16'd6,   8'd0,   1'b1, 1'b0}, // R5 set at wrap
        '{8'd5, 2'd2, 8'd100, 2'd2, 8'd250, 16'd106, 8'd100, 1'b1, 1'b0}, // R5 before match
        '{8'd5, 2'd2, 8'd100, 2'd2, 8'd250, 16'd107, 8'd101, 1'b0, 1'b1}, // R5 cleared at match
        '{8'd5, 2'd2, 8'd100, 2'd3, 8'd250, 16'd106, 8'd100, 1'b0, 1'b0}, // R5 inverted
        '{8'd5, 2'd2, 8'd100, 2'd3, 8'd250, 16'd107, 8'd101, 1'b1, 1'b1}, // R5 inverted match
        '{8'd6, 2'd3, 8'd100, 2'd2, 8'd250, 16'd160, 8'd100, 1'b0, 1'b0}, // R6 down-count before match
        '{8'd6, 2'd3, 8'd100, 2'd2, 8'd250, 16'd161, 8'd99,  1'b1, 1'b1}, // R6 set on down match
        '{8'd7, 2'd3, 8'd255, 2'd2, 8'd0,   16'd3,   8'd3,   1'b1, 1'b0}, // R7 max holds high
        '{8'd7, 2'd3, 8'd0,   2'd3, 8'd0,   16'd3,   8'd3,   1'b1, 1'b0}  // R7 zero inverted high
    };

    task automatic check(input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    // channel A: compare loaded directly, pin level forced low, then final settings
    task automatic setup(input logic [1:0] mode, input logic [7:0] cmp,
                         input logic [1:0] om, input logic [7:0] start);
        wr(3'd3, 8'd0);
        wr(3'd1, cmp);
        wr(3'd4, 8'd2);
        wr(3'd5, 8'd1);
        wr(3'd4, {6'd0, om});
        wr(3'd3, {6'd0, mode});
        wr(3'd0, start);
        wr(3'd6, 8'd7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 count", count, 0);
        check("R12 wave_a", wave_a, 0);
        check("R12 wave_b", wave_b, 0);
        check("R12 flags", {ovf_flag, match_flag}, 0);

        for (int i = 0; i < NV; i++) begin
            setup(VECS[i].mode, VECS[i].cmp, VECS[i].om, VECS[i].start);
            run(int'(VECS[i].n));
            check($sformatf("R%0d vec %0d count", VECS[i].tag, i), count, VECS[i].ecnt);
            check($sformatf("R%0d vec %0d wave_a", VECS[i].tag, i), wave_a, VECS[i].ewave);
            check($sformatf("R%0d vec %0d flag_a", VECS[i].tag, i), match_flag[0], VECS[i].eflag);
        end

        // R10 force in free-running: set action, no flag, counter untouched
        setup(2'd0, 8'd10, 2'd3, 8'd0);
        wr(3'd5, 8'd1);
        check("R10 force sets pin", wave_a, 1);
        check("R10 force no flag", match_flag[0], 0);
        check("R10 force keeps count", count, 0);
        wr(3'd4, 8'd0);
        check("R4 mode off holds pin low", wave_a, 0);

        // R10 force ignored in PWM, then R8 buffered compare
        setup(2'd2, 8'd100, 2'd2, 8'd250);
        run(6);
        check("R5 high after wrap", wave_a, 1);
        wr(3'd5, 8'd1);
        check("R10 force ignored in PWM", wave_a, 1);
        wr(3'd1, 8'd20);
        run(30);
        check("R8 new compare not yet active", wave_a, 1);
        check("R8 count", count, 30);
        run(226);
        check("R8 wrap count", count, 0);
        check("R8 set at wrap", wave_a, 1);
        run(21);
        check("R8 new compare active after reload", wave_a, 0);

        // R2 overflow at 255 and R11 clearing
        setup(2'd0, 8'd10, 2'd0, 8'd254);
        run(2);
        check("R2 wrap count", count, 0);
        check("R2 overflow set", ovf_flag, 1);
        run(3);
        check("R11 overflow sticky", ovf_flag, 1);
        wr(3'd6, 8'd4);
        check("R11 overflow cleared", ovf_flag, 0);

        // R6 overflow at bottom of dual-slope only
        setup(2'd3, 8'd100, 2'd0, 8'd253);
        run(3);
        check("R6 turned at top", count, 254);
        check("R6 no overflow at top", ovf_flag, 0);
        run(254);
        check("R6 reached zero", count, 0);
        check("R6 no overflow yet", ovf_flag, 0);
        run(1);
        check("R6 count after turn", count, 1);
        check("R6 overflow at bottom", ovf_flag, 1);

        // channel B, R1 select codes 2, 4 (bits 3:2), 5 (bit 1), 6 (bit 1)
        wr(3'd3, 8'd0);
        wr(3'd2, 8'd7);
        wr(3'd4, 8'h8);
        wr(3'd5, 8'h2);
        wr(3'd4, 8'h4);
        wr(3'd0, 8'd0);
        wr(3'd6, 8'd7);
        check("R1 channel B forced low", wave_b, 0);
        run(8);
        check("R1 channel B toggled", wave_b, 1);
        check("R1 channel B flag", match_flag[1], 1);
        check("R1 count", count, 8);
        wr(3'd6, 8'h2);
        check("R11 flag B cleared", match_flag[1], 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule